// File: doc/BRIEF.md
# Rolling-Code Frame Assembler

This block builds the 67-bit code word of a one-way rolling-code transmitter. A request snapshots the button nibble, the 16-bit counter, the 32-bit serial number, the 48-bit seed, the option bits and the low-battery flag. From that snapshot the block forms a 32-bit plaintext word and hands it to an external block cipher through a start/done handshake. It then packs the returned ciphertext with the fixed identification fields, the battery flag and a two-bit check code, and holds the finished frame for a serializer. The serializer shifts the frame out starting from bit 0.

Some button codes, when seed sending is enabled, make a seed frame instead of a hopped frame. A seed frame uses no cipher: the seed words fill the low 48 bits and are followed by the upper half of the serial field. A frame flagged as sent after the delay point, with delay marking enabled, carries the low nibble of its discrimination field inverted. The receiver uses this to tell delayed words from normal ones.

Top module: `rcode_frame_asm`

## Requirements
- R1: The plaintext `cipher_pt_o` is laid out as follows. Bits [31:28] hold the button nibble and bit 27 holds the independent-counter flag. Bit 26 holds the overflow flag, bits [25:24] the two user bits, bits [23:16] serial bits [7:0], and bits [15:0] the counter value.
- R2: When both `delayed_i` and `opt_delay_mark_i` were high at the request, plaintext bits [19:16] are the inverse of serial bits [3:0]. In every other case they are equal to serial bits [3:0].
- R3: In a hopped frame, bits [31:0] are the ciphertext returned by the cipher. With `opt_full_serial_i`=1, bits [63:32] are the full serial number. With `opt_full_serial_i`=0, bits [59:32] are serial bits [27:0] and bits [63:60] are the button nibble.
- R4: Frame bit 64 equals `low_batt_i` as sampled at the request.
- R5: Frame bit 65 is the XOR of frame bits 0 to 64. Frame bit 66 is the XOR of the odd-numbered frame bits from 1 to 63.
- R6: A seed frame is made when `opt_seed_en_i`=1 and one of two conditions holds: the button nibble is 4'b1001, or it is 4'b0011 with `delayed_i`=1. A seed frame carries the seed in bits [47:0]. Bits [63:48] hold serial bits [31:16], or the button nibble followed by serial bits [27:16] when `opt_full_serial_i`=0. Button 4'b0011 without `delayed_i`, and any button with `opt_seed_en_i`=0, give a hopped frame.
- R7: A request accepted while idle raises `cipher_start_o` for exactly one cycle, in the cycle after the request edge. The plaintext stays stable until the ciphertext is accepted. `cipher_done_i` is honoured only while a ciphertext is awaited. `frame_valid_o` rises in the cycle after the edge that samples `cipher_done_i`.
- R8: `frame_valid_o` stays high and `frame_o` stays unchanged until `frame_ack_i` is sampled high. `frame_valid_o` is low in the following cycle. `req_i` has no effect while a frame is being built or held.
- R9: A seed frame never raises `cipher_start_o`. Its `frame_valid_o` rises in the second cycle after the request edge.
- R10: During reset, `cipher_start_o`, `frame_valid_o`, `cipher_pt_o` and `frame_o` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_i | input | 1 | Start building a frame (used when idle) |
| delayed_i | input | 1 | Frame is sent after the delay point |
| button_i | input | 4 | Button status nibble |
| sync_i | input | 16 | Counter value |
| serial_i | input | 32 | Serial number |
| seed_i | input | 48 | Seed words, lowest word in bits [15:0] |
| opt_full_serial_i | input | 1 | Send full 32-bit serial number |
| opt_seed_en_i | input | 1 | Allow seed frames |
| opt_delay_mark_i | input | 1 | Invert discrimination low nibble on delayed frames |
| opt_indep_i | input | 1 | Independent-counter flag |
| opt_ovf_i | input | 1 | Overflow flag |
| opt_user_i | input | 2 | User bits |
| low_batt_i | input | 1 | Low-battery flag |
| cipher_start_o | output | 1 | One-cycle request to the cipher |
| cipher_pt_o | output | 32 | Plaintext for the cipher |
| cipher_done_i | input | 1 | Ciphertext is valid |
| cipher_ct_i | input | 32 | Ciphertext |
| frame_valid_o | output | 1 | Frame ready for the serializer |
| frame_o | output | 67 | Assembled frame, bit 0 sent first |
| frame_ack_i | input | 1 | Serializer has taken the frame |

## Verification
The assertions watch the handshake on every cycle. They check that the cipher start is a single pulse and that the plaintext stays still while the ciphertext is awaited. They also check that a frame follows one cycle after done, that seed frames appear on the second cycle, and that a held frame neither changes nor drops before its acknowledge. The content of the frame can only be shown by the bench's scenarios. These cover the plaintext bit layout, delay-nibble inversion, serial truncation with button substitution, the choice between seed and hopped frames for each button code, and the two parity bits. The bench also checks that a second request or a stray done during a build leaves the frame untouched.

// File: rtl/rcf_pkg.sv
package rcf_pkg;
  parameter int BTN_W    = 4;
  parameter int SYNC_W   = 16;
  parameter int SER_W    = 32;
  parameter int SEED_W   = 48;
  parameter int CT_W     = 32;
  parameter int USER_W   = 2;
  parameter int SERLSB_W = 8;
  parameter int NIB_W    = 4;

  localparam int DISC_W   = SERLSB_W + USER_W + 2;
  localparam int PT_W     = BTN_W + DISC_W + SYNC_W;
  localparam int BODY_W   = CT_W + SER_W + 1;
  localparam int CHK_W    = 2;
  localparam int FRAME_W  = BODY_W + CHK_W;
  localparam int SER_HI_W = CT_W + SER_W - SEED_W;

  localparam logic [BTN_W-1:0] BTN_SEED_NOW = 4'b1001;
  localparam logic [BTN_W-1:0] BTN_SEED_DLY = 4'b0011;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_CALC = 2'd1,
    ST_WAIT = 2'd2,
    ST_HOLD = 2'd3
  } asm_state_e;

  typedef struct packed {
    logic [BTN_W-1:0]  btn;
    logic [SYNC_W-1:0] sync;
    logic [SER_W-1:0]  serial;
    logic [SEED_W-1:0] seed;
    logic              full_ser;
    logic              seed_en;
    logic              delay_mark;
    logic              indep;
    logic              ovf;
    logic [USER_W-1:0] user;
    logic              low_batt;
    logic              delayed;
  } snap_t;
endpackage

// File: rtl/rcf_plaintext.sv
module rcf_plaintext
  import rcf_pkg::*;
(
  input  logic [BTN_W-1:0]    btn_i,
  input  logic [SYNC_W-1:0]   sync_i,
  input  logic [SERLSB_W-1:0] ser_lsb_i,
  input  logic                indep_i,
  input  logic                ovf_i,
  input  logic [USER_W-1:0]   user_i,
  input  logic                delay_mark_i,
  input  logic                delayed_i,
  input  logic                seed_en_i,
  output logic [PT_W-1:0]     pt_o,
  output logic                seed_sel_o
);
  logic [DISC_W-1:0] disc;

  always_comb begin
    disc = {indep_i, ovf_i, user_i, ser_lsb_i};
    if (delayed_i && delay_mark_i) begin
      disc[NIB_W-1:0] = ~disc[NIB_W-1:0];
    end
  end

  assign pt_o = {btn_i, disc, sync_i};

  assign seed_sel_o = seed_en_i &&
                      ((btn_i == BTN_SEED_NOW) ||
                       ((btn_i == BTN_SEED_DLY) && delayed_i));
endmodule

// File: rtl/rcf_pack.sv
module rcf_pack
  import rcf_pkg::*;
(
  input  logic [BTN_W-1:0]  btn_i,
  input  logic [SER_W-1:0]  serial_i,
  input  logic [SEED_W-1:0] seed_i,
  input  logic              full_ser_i,
  input  logic              low_batt_i,
  input  logic              seed_sel_i,
  input  logic [CT_W-1:0]   ct_i,
  output logic [BODY_W-1:0] body_o
);
  logic [SER_W-1:0] ser_fld;

  always_comb begin
    if (full_ser_i) begin
      ser_fld = serial_i;
    end else begin
      ser_fld = {btn_i, serial_i[SER_W-BTN_W-1:0]};
    end
  end

  always_comb begin
    if (seed_sel_i) begin
      body_o = {low_batt_i, ser_fld[SER_W-1 -: SER_HI_W], seed_i};
    end else begin
      body_o = {low_batt_i, ser_fld, ct_i};
    end
  end
endmodule

// File: rtl/rcf_parity.sv
module rcf_parity #(
  parameter int N = 65
) (
  input  logic [N-1:0] data_i,
  output logic [1:0]   chk_o
);
  logic all_c [N+1];
  logic odd_c [N+1];

  assign all_c[0] = 1'b0;
  assign odd_c[0] = 1'b0;

  for (genvar gi = 0; gi < N; gi++) begin : g_bit
    assign all_c[gi+1] = all_c[gi] ^ data_i[gi];
    if ((gi % 2) == 1) begin : g_odd
      assign odd_c[gi+1] = odd_c[gi] ^ data_i[gi];
    end else begin : g_even
      assign odd_c[gi+1] = odd_c[gi];
    end
  end

  assign chk_o = {odd_c[N], all_c[N]};
endmodule

// File: rtl/rcode_frame_asm.sv
module rcode_frame_asm
  import rcf_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_i,
  input  logic               delayed_i,
  input  logic [3:0]         button_i,
  input  logic [15:0]        sync_i,
  input  logic [31:0]        serial_i,
  input  logic [47:0]        seed_i,
  input  logic               opt_full_serial_i,
  input  logic               opt_seed_en_i,
  input  logic               opt_delay_mark_i,
  input  logic               opt_indep_i,
  input  logic               opt_ovf_i,
  input  logic [1:0]         opt_user_i,
  input  logic               low_batt_i,
  output logic               cipher_start_o,
  output logic [31:0]        cipher_pt_o,
  input  logic               cipher_done_i,
  input  logic [31:0]        cipher_ct_i,
  output logic               frame_valid_o,
  output logic [66:0]        frame_o,
  input  logic               frame_ack_i
);
  asm_state_e           state_q, state_d;
  snap_t                snap_q, snap_d;
  logic                 snap_ld;
  logic                 frame_ld;
  logic [FRAME_W-1:0]   frame_q, frame_d;
  logic [PT_W-1:0]      pt;
  logic                 seed_sel;
  logic [BODY_W-1:0]    body;
  logic [CHK_W-1:0]     chk;

  always_comb begin
    snap_d = '{btn:        button_i,
               sync:       sync_i,
               serial:     serial_i,
               seed:       seed_i,
               full_ser:   opt_full_serial_i,
               seed_en:    opt_seed_en_i,
               delay_mark: opt_delay_mark_i,
               indep:      opt_indep_i,
               ovf:        opt_ovf_i,
               user:       opt_user_i,
               low_batt:   low_batt_i,
               delayed:    delayed_i};
  end

  rcf_plaintext u_pt (
    .btn_i        (snap_q.btn),
    .sync_i       (snap_q.sync),
    .ser_lsb_i    (snap_q.serial[SERLSB_W-1:0]),
    .indep_i      (snap_q.indep),
    .ovf_i        (snap_q.ovf),
    .user_i       (snap_q.user),
    .delay_mark_i (snap_q.delay_mark),
    .delayed_i    (snap_q.delayed),
    .seed_en_i    (snap_q.seed_en),
    .pt_o         (pt),
    .seed_sel_o   (seed_sel)
  );

  rcf_pack u_pack (
    .btn_i      (snap_q.btn),
    .serial_i   (snap_q.serial),
    .seed_i     (snap_q.seed),
    .full_ser_i (snap_q.full_ser),
    .low_batt_i (snap_q.low_batt),
    .seed_sel_i (seed_sel),
    .ct_i       (cipher_ct_i),
    .body_o     (body)
  );

  rcf_parity #(.N(BODY_W)) u_par (
    .data_i (body),
    .chk_o  (chk)
  );

  assign frame_d = {chk, body};

  // next-state logic
  always_comb begin
    state_d  = state_q;
    snap_ld  = 1'b0;
    frame_ld = 1'b0;
    case (state_q)
      ST_IDLE: begin
        if (req_i) begin
          snap_ld = 1'b1;
          state_d = ST_CALC;
        end
      end
      ST_CALC: begin
        if (seed_sel) begin
          frame_ld = 1'b1;
          state_d  = ST_HOLD;
        end else begin
          state_d  = ST_WAIT;
        end
      end
      ST_WAIT: begin
        if (cipher_done_i) begin
          frame_ld = 1'b1;
          state_d  = ST_HOLD;
        end
      end
      ST_HOLD: begin
        if (frame_ack_i) begin
          state_d = ST_IDLE;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
    end else begin
      state_q <= state_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      snap_q <= '0;
    end else if (snap_ld) begin
      snap_q <= snap_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      frame_q <= '0;
    end else if (frame_ld) begin
      frame_q <= frame_d;
    end
  end

  assign cipher_start_o = (state_q == ST_CALC) && !seed_sel;
  assign cipher_pt_o    = pt;
  assign frame_valid_o  = (state_q == ST_HOLD);
  assign frame_o        = frame_q;

  // R7: start is a single-cycle pulse
  p_start_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    cipher_start_o |=> !cipher_start_o);

  // R7: plaintext held while the ciphertext is awaited
  p_pt_stable_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_WAIT) |-> $stable(cipher_pt_o));

  // R7: frame follows the accepted ciphertext by one cycle
  p_valid_after_done_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ((state_q == ST_WAIT) && cipher_done_i) |=> frame_valid_o);

  // R8: held frame stays valid and unchanged until acknowledged
  p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_valid_o && !frame_ack_i) |=> (frame_valid_o && $stable(frame_o)));

  // R8: acknowledge releases the frame
  p_release_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_valid_o && frame_ack_i) |=> !frame_valid_o);

  // R9: seed frames skip the cipher and are ready next cycle
  p_seed_fast_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ((state_q == ST_CALC) && seed_sel) |=> (frame_valid_o && !cipher_start_o));
endmodule

// File: tb/rcode_frame_asm_tb.sv
module rcode_frame_asm_tb;
  typedef struct packed {
    logic [3:0]  btn;
    logic [15:0] sync;
    logic [31:0] serial;
    logic [47:0] seed;
    logic        xs;
    logic        sen;
    logic        dm;
    logic        ind;
    logic        ovf;
    logic [1:0]  usr;
    logic        lb;
    logic        dly;
  } vec_t;

  localparam int NV = 10;
  // btn sync serial seed xs sen dm ind ovf usr lb dly
  localparam vec_t VECS [NV] = '{
    '{4'h1, 16'h1234, 32'hDEADBEEF, 48'h111122223333, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 2'b00, 1'b0, 1'b0},
    '{4'h2, 16'hFFFF, 32'hA5A5C3C3, 48'h0,            1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 2'b10, 1'b1, 1'b0},
    '{4'h4, 16'h0001, 32'h12345678, 48'h0,            1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 2'b01, 1'b0, 1'b1},
    '{4'h4, 16'h8000, 32'h12345678, 48'h0,            1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 2'b11, 1'b1, 1'b1},
    '{4'h9, 16'h0042, 32'hCAFEF00D, 48'hABCDEF012345, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 2'b00, 1'b0, 1'b0},
    '{4'h9, 16'h0042, 32'hCAFEF00D, 48'hABCDEF012345, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 2'b00, 1'b1, 1'b0},
    '{4'h3, 16'h0777, 32'h0BADC0DE, 48'h5555AAAA5555, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 2'b01, 1'b0, 1'b0},
    '{4'h3, 16'h0777, 32'h0BADC0DE, 48'h5555AAAA5555, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 2'b01, 1'b1, 1'b1},
    '{4'hF, 16'hFFFF, 32'hFFFFFFFF, 48'hFFFFFFFFFFFF, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 2'b11, 1'b1, 1'b1},
    '{4'h0, 16'h0000, 32'h00000000, 48'h0,            1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 2'b00, 1'b0, 1'b0}
  };
  localparam string TAGS [NV] = '{"R3", "R3", "R2", "R2", "R6", "R6", "R6", "R6", "R5", "R4"};

  logic        clk;
  logic        rst_n;
  logic        req;
  logic        dly;
  logic [3:0]  btn;
  logic [15:0] sync;
  logic [31:0] serial;
  logic [47:0] seed;
  logic        xs, sen, dm, ind, ovf, lb;
  logic [1:0]  usr;
  logic        start;
  logic [31:0] pt;
  logic        done;
  logic [31:0] ct;
  logic        fvalid;
  logic [66:0] frame;
  logic        ack;

  int checks = 0;
  int errors = 0;

  rcode_frame_asm u_dut (
    .clk               (clk),
    .rst_n             (rst_n),
    .req_i             (req),
    .delayed_i         (dly),
    .button_i          (btn),
    .sync_i            (sync),
    .serial_i          (serial),
    .seed_i            (seed),
    .opt_full_serial_i (xs),
    .opt_seed_en_i     (sen),
    .opt_delay_mark_i  (dm),
    .opt_indep_i       (ind),
    .opt_ovf_i         (ovf),
    .opt_user_i        (usr),
    .low_batt_i        (lb),
    .cipher_start_o    (start),
    .cipher_pt_o       (pt),
    .cipher_done_i     (done),
    .cipher_ct_i       (ct),
    .frame_valid_o     (fvalid),
    .frame_o           (frame),
    .frame_ack_i       (ack)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic check(input string tag, input string what,
                       input logic [66:0] act, input logic [66:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_pt(input vec_t v);
    logic [11:0] d;
    d = {v.ind, v.ovf, v.usr, v.serial[7:0]};
    if (v.dly && v.dm) d[3:0] = ~d[3:0];
    return {v.btn, d, v.sync};
  endfunction

  function automatic logic is_seed(input vec_t v);
    return v.sen && ((v.btn == 4'b1001) || ((v.btn == 4'b0011) && v.dly));
  endfunction

  function automatic logic [31:0] cmodel(input logic [31:0] p);
    return {p[7:0], p[31:8]} ^ 32'h9E3779B9;
  endfunction

  function automatic logic [66:0] exp_frame(input vec_t v, input logic [31:0] c);
    logic [64:0] b;
    logic [31:0] sf;
    logic c0, c1;
    sf = v.xs ? v.serial : {v.btn, v.serial[27:0]};
    if (is_seed(v)) b = {v.lb, sf[31:16], v.seed};
    else            b = {v.lb, sf, c};
    c0 = 1'b0;
    c1 = 1'b0;
    for (int i = 0; i < 65; i++) begin
      c0 ^= b[i];
      if ((i % 2) == 1) c1 ^= b[i];
    end
    return {c1, c0, b};
  endfunction

  task automatic drive(input vec_t v);
    btn = v.btn; sync = v.sync; serial = v.serial; seed = v.seed;
    xs = v.xs; sen = v.sen; dm = v.dm; ind = v.ind; ovf = v.ovf;
    usr = v.usr; lb = v.lb; dly = v.dly;
  endtask

  task automatic release_frame(input logic [66:0] held);
    @(negedge clk);
    check("R8", "valid held", {66'b0, fvalid}, 67'd1);
    check("R8", "frame held", frame, held);
    ack = 1'b1;
    @(negedge clk);
    ack = 1'b0;
    check("R8", "valid after ack", {66'b0, fvalid}, 67'd0);
  endtask

  task automatic run_vec(input vec_t v, input string tag);
    logic [66:0] ef;
    @(negedge clk);
    drive(v);
    req = 1'b1;
    @(negedge clk);
    req = 1'b0;
    if (is_seed(v)) begin
      check("R9", "no cipher start", {66'b0, start}, 67'd0);
      check("R9", "not yet valid", {66'b0, fvalid}, 67'd0);
      @(negedge clk);
      ef = exp_frame(v, 32'h0);
      check("R9", "seed valid", {66'b0, fvalid}, 67'd1);
      check(tag, "seed frame", frame, ef);
    end else begin
      check("R7", "cipher start", {66'b0, start}, 67'd1);
      check("R1", "plaintext", {35'b0, pt}, {35'b0, exp_pt(v)});
      @(negedge clk);
      check("R7", "start pulse ends", {66'b0, start}, 67'd0);
      done = 1'b1;
      ct = cmodel(exp_pt(v));
      @(negedge clk);
      done = 1'b0;
      ef = exp_frame(v, cmodel(exp_pt(v)));
      check("R7", "valid after done", {66'b0, fvalid}, 67'd1);
      check(tag, "hopped frame", frame, ef);
    end
    check("R4", "battery bit", {66'b0, frame[64]}, {66'b0, v.lb});
    check("R5", "check bits", {65'b0, frame[66:65]}, {65'b0, ef[66:65]});
    release_frame(ef);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [66:0] ef;
    rst_n = 1'b0;
    req = 1'b0; done = 1'b0; ct = '0; ack = 1'b0;
    drive(VECS[9]);
    repeat (3) @(negedge clk);
    check("R10", "start in reset", {66'b0, start}, 67'd0);
    check("R10", "valid in reset", {66'b0, fvalid}, 67'd0);
    check("R10", "pt in reset", {35'b0, pt}, 67'd0);
    check("R10", "frame in reset", frame, 67'd0);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      run_vec(VECS[i], TAGS[i]);
    end

    // R7: stray done while idle has no effect
    @(negedge clk);
    done = 1'b1;
    ct = 32'hFFFF0000;
    @(negedge clk);
    done = 1'b0;
    check("R7", "stray done ignored", {66'b0, fvalid}, 67'd0);
    check("R7", "no start from done", {66'b0, start}, 67'd0);

    // R8: requests during a build and during hold are ignored
    @(negedge clk);
    drive(VECS[0]);
    req = 1'b1;
    @(negedge clk);
    req = 1'b0;
    @(negedge clk);
    drive(VECS[1]);
    req = 1'b1;
    @(negedge clk);
    req = 1'b0;
    check("R8", "no restart while waiting", {66'b0, start}, 67'd0);
    check("R8", "pt unchanged while busy", {35'b0, pt}, {35'b0, exp_pt(VECS[0])});
    done = 1'b1;
    ct = cmodel(exp_pt(VECS[0]));
    @(negedge clk);
    done = 1'b0;
    ef = exp_frame(VECS[0], cmodel(exp_pt(VECS[0])));
    check("R8", "frame from first request", frame, ef);
    drive(VECS[4]);
    req = 1'b1;
    @(negedge clk);
    req = 1'b0;
    check("R8", "hold ignores req", frame, ef);
    check("R8", "hold valid", {66'b0, fvalid}, 67'd1);
    repeat (3) @(negedge clk);
    release_frame(ef);
    @(negedge clk);
    check("R8", "idle after release", {66'b0, start | fvalid}, 67'd0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule